// File: doc/BRIEF.md
# Dual-Family Hough Peak Locator

Once a frame's line votes have all been accumulated, this block finds the single strongest line. The votes are held in two families of accumulator banks, with one bank per angle step in each family. The two families cover adjacent quarter turns of angle, so together they span half a turn. The block issues one read address per cycle to every bank at once. Each bank returns its count one cycle later. For each family, a comparator network reduces the per-bank counts at that address to one candidate. A running search then keeps the family's best count, along with the address and the step index where that count was found.

When the scan ends, a two-way comparison picks the winning family. The block then reports the line. The distance is the winning address. The angle is the family's base angle plus the step index times the step size. The vote count and the winning family are also reported.

A start pulse begins a scan. A done flag marks that the results are valid, and it stays high until the next accepted start. If no bank holds a nonzero count, a no-line flag is raised together with done.

Top module: `houghPeakFinder`

## Requirements
- R1: After reset, done, noLine, familyB, peakCount, distOut and angleOut are all 0.
- R2: A start sampled while idle begins a scan. rdAddr steps from 0 up to DEPTH-1, one address per cycle, and each bank's data is taken one cycle after its address. done rises on the edge DEPTH+2 clock cycles after the edge that sampled start.
- R3: Within each family the result is the largest count over all banks and addresses. It comes with the address and the bank index (step index) where that count occurs. Bank i occupies bits [i*CNT_W +: CNT_W] of aData or bData.
- R4: Within a family, if counts are equal, the lower address wins. At the same address, the lower step index wins.
- R5: The b family is reported (familyB=1) only when its best count is strictly greater than the a family's best count. On equal counts the a family wins.
- R6: distOut equals the winning address. angleOut equals step*STEP_SIZE for the a family, and B_BASE + step*STEP_SIZE for the b family. With the defaults these are step*5 and 90 + step*5.
- R7: If every count in both families is zero, noLine is 1 together with done, and peakCount is 0. Otherwise noLine is 0 and peakCount is nonzero.
- R8: A start pulse during a scan that is still running has no effect. The results and the timing of done follow the first start.
- R9: While done is high and no start arrives, all outputs hold. An accepted start clears done and noLine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (sampled when idle) |
| aData | input | NUM_STEPS*CNT_W | Read data from the a-family banks, one lane per step |
| bData | input | NUM_STEPS*CNT_W | Read data from the b-family banks, one lane per step |
| rdAddr | output | ADDR_W | Read address shared by all banks |
| done | output | 1 | Results valid |
| noLine | output | 1 | All counts were zero |
| familyB | output | 1 | Winner came from the b family |
| peakCount | output | CNT_W | Winning vote count |
| distOut | output | ADDR_W | Distance parameter (winning address) |
| angleOut | output | ANGLE_W | Angle parameter |

## Verification
Two functions can fall in the same cycle: the in-family tie-break, and the cross-family comparison. Both are decided when equal counts meet. The bench provokes them by planting equal counts in two banks at one address, at two addresses within one bank, and at the maximum of both families at once. It then checks that the lower address, the lower step and the a family win, in that order. A start pulse placed mid-scan is also judged. The first scan must still finish with unchanged timing and results, which shows that the restart path and the completion path do not interfere.

// File: rtl/houghPeakPkg.sv
package houghPeakPkg;
  typedef struct packed {
    logic clear;    // new scan accepted: wipe running bests and outputs
    logic capture;  // bank data for capAddr valid this cycle
    logic finish;   // running bests final: produce results
  } hpfStrobes_t;
endpackage

// File: rtl/hpfControl.sv
module hpfControl
  import houghPeakPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] capAddr,
  output hpfStrobes_t       strobes,
  output logic              done
);
  typedef enum logic [1:0] {IDLE, SCAN, DRAIN, FINAL} hpfState_t;

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  hpfState_t        state;
  logic [ADDR_W-1:0] addrQ;
  logic              validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= IDLE;
      addrQ   <= '0;
      validQ  <= 1'b0;
      capAddr <= '0;
      done    <= 1'b0;
    end else begin
      validQ  <= (state == SCAN);
      capAddr <= addrQ;
      case (state)
        IDLE: if (start) begin
          state <= SCAN;
          addrQ <= '0;
          done  <= 1'b0;
        end
        SCAN: begin
          if (addrQ == LAST_ADDR) state <= DRAIN;
          else                    addrQ <= addrQ + 1'b1;
        end
        DRAIN: state <= FINAL;
        default: begin
          state <= IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end

  assign rdAddr          = addrQ;
  assign strobes.clear   = (state == IDLE) && start;
  assign strobes.capture = validQ;
  assign strobes.finish  = (state == FINAL);
endmodule

// File: rtl/hpfDatapath.sv
module hpfDatapath
  import houghPeakPkg::*;
#(
  parameter int NUM_STEPS = 4,
  parameter int ADDR_W    = 4,
  parameter int CNT_W     = 8,
  parameter int ANGLE_W   = 8,
  parameter int STEP_SIZE = 5,
  parameter int B_BASE    = 90,
  parameter int STEP_W    = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  hpfStrobes_t                strobes,
  input  logic [ADDR_W-1:0]          capAddr,
  input  logic [NUM_STEPS*CNT_W-1:0] aData,
  input  logic [NUM_STEPS*CNT_W-1:0] bData,
  output logic                       noLine,
  output logic                       familyB,
  output logic [CNT_W-1:0]           peakCount,
  output logic [ADDR_W-1:0]          distOut,
  output logic [ANGLE_W-1:0]         angleOut
);
  logic [NUM_STEPS*CNT_W-1:0] famData [2];
  logic [CNT_W-1:0]  bestVal  [2];
  logic [ADDR_W-1:0] bestAddr [2];
  logic [STEP_W-1:0] bestStep [2];

  assign famData[0] = aData;
  assign famData[1] = bData;

  for (genvar f = 0; f < 2; f++) begin : g_family
    logic [CNT_W-1:0]  laneVal;
    logic [STEP_W-1:0] laneStep;

    // reduce banks at this address; strict compare keeps the lower step
    always_comb begin
      laneVal  = famData[f][CNT_W-1:0];
      laneStep = '0;
      for (int i = 1; i < NUM_STEPS; i++) begin
        if (famData[f][i*CNT_W +: CNT_W] > laneVal) begin
          laneVal  = famData[f][i*CNT_W +: CNT_W];
          laneStep = STEP_W'(i);
        end
      end
    end

    // running best; strict compare keeps the earlier address
    always_ff @(posedge clk) begin
      if (!rstN || strobes.clear) begin
        bestVal[f]  <= '0;
        bestAddr[f] <= '0;
        bestStep[f] <= '0;
      end else if (strobes.capture && laneVal > bestVal[f]) begin
        bestVal[f]  <= laneVal;
        bestAddr[f] <= capAddr;
        bestStep[f] <= laneStep;
      end
    end
  end

  logic              pickB;
  logic [STEP_W-1:0] winStep;
  logic [ANGLE_W-1:0] baseAngle;

  assign pickB     = bestVal[1] > bestVal[0];
  assign winStep   = pickB ? bestStep[1] : bestStep[0];
  assign baseAngle = pickB ? ANGLE_W'(B_BASE) : '0;

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) begin
      noLine    <= 1'b0;
      familyB   <= 1'b0;
      peakCount <= '0;
      distOut   <= '0;
      angleOut  <= '0;
    end else if (strobes.finish) begin
      noLine    <= (bestVal[0] == '0) && (bestVal[1] == '0);
      familyB   <= pickB;
      peakCount <= pickB ? bestVal[1] : bestVal[0];
      distOut   <= pickB ? bestAddr[1] : bestAddr[0];
      angleOut  <= baseAngle + ANGLE_W'(winStep) * ANGLE_W'(STEP_SIZE);
    end
  end
endmodule

// File: rtl/houghPeakFinder.sv
module houghPeakFinder
  import houghPeakPkg::*;
#(
  parameter int NUM_STEPS = 4,
  parameter int DEPTH     = 16,
  parameter int CNT_W     = 8,
  parameter int ANGLE_W   = 8,
  parameter int STEP_SIZE = 5,
  parameter int B_BASE    = 90,
  parameter int ADDR_W    = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [NUM_STEPS*CNT_W-1:0] aData,
  input  logic [NUM_STEPS*CNT_W-1:0] bData,
  output logic [ADDR_W-1:0]          rdAddr,
  output logic                       done,
  output logic                       noLine,
  output logic                       familyB,
  output logic [CNT_W-1:0]           peakCount,
  output logic [ADDR_W-1:0]          distOut,
  output logic [ANGLE_W-1:0]         angleOut
);
  hpfStrobes_t       strobes;
  logic [ADDR_W-1:0] capAddr;

  hpfControl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .rdAddr(rdAddr), .capAddr(capAddr), .strobes(strobes), .done(done)
  );

  hpfDatapath #(
    .NUM_STEPS(NUM_STEPS), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .ANGLE_W(ANGLE_W), .STEP_SIZE(STEP_SIZE), .B_BASE(B_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .capAddr(capAddr),
    .aData(aData), .bData(bData),
    .noLine(noLine), .familyB(familyB), .peakCount(peakCount),
    .distOut(distOut), .angleOut(angleOut)
  );
endmodule

// File: rtl/hpfChecker.sv
module hpfChecker #(
  parameter int DEPTH   = 16,
  parameter int CNT_W   = 8,
  parameter int ADDR_W  = 4,
  parameter int ANGLE_W = 8,
  parameter int B_BASE  = 90
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               done,
  input logic               noLine,
  input logic               familyB,
  input logic [CNT_W-1:0]   peakCount,
  input logic [ADDR_W-1:0]  distOut,
  input logic [ANGLE_W-1:0] angleOut
);
  logic        busyQ;
  logic [31:0] cycQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cycQ  <= '0;
    end else if (start && (!busyQ || done)) begin
      busyQ <= 1'b1;
      cycQ  <= '0;
    end else if (busyQ && done) begin
      busyQ <= 1'b0;
    end else if (busyQ) begin
      cycQ <= cycQ + 1;
    end
  end

  // R2
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (busyQ && cycQ == 32'(DEPTH + 2)));

  // R7
  noline_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    noLine |-> (done && peakCount == '0));

  // R7
  line_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !noLine) |-> (peakCount != '0));

  // R6
  angle_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (familyB ? (angleOut >= ANGLE_W'(B_BASE)) : (angleOut < ANGLE_W'(B_BASE))));

  // R9
  hold_results_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(distOut) && $stable(angleOut)
                          && $stable(peakCount) && $stable(familyB)));
endmodule

bind houghPeakFinder hpfChecker #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .ANGLE_W(ANGLE_W), .B_BASE(B_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .noLine(noLine),
  .familyB(familyB), .peakCount(peakCount), .distOut(distOut), .angleOut(angleOut)
);

// File: tb/sim_houghPeakFinder.sv
module sim_houghPeakFinder;
  localparam int NS = 4, D = 16, CW = 8, AW = 4, GW = 8;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [NS*CW-1:0] aData = '0, bData = '0;
  logic [AW-1:0] rdAddr;
  logic done, noLine, familyB;
  logic [CW-1:0] peakCount;
  logic [AW-1:0] distOut;
  logic [GW-1:0] angleOut;

  logic [CW-1:0] memA [NS][D];
  logic [CW-1:0] memB [NS][D];

  int checks = 0, fails = 0, lastLat = 0;

  always #10 clk = ~clk;

  houghPeakFinder u0 (
    .clk(clk), .rstN(rstN), .start(start), .aData(aData), .bData(bData),
    .rdAddr(rdAddr), .done(done), .noLine(noLine), .familyB(familyB),
    .peakCount(peakCount), .distOut(distOut), .angleOut(angleOut)
  );

  always @(posedge clk) begin
    for (int i = 0; i < NS; i++) begin
      aData[i*CW +: CW] <= memA[i][rdAddr];
      bData[i*CW +: CW] <= memB[i][rdAddr];
    end
  end

  // {family, bank, addr, peak}
  localparam logic [14:0] VEC [6] = '{
    {1'b0, 2'd1, 4'd3,  8'd50},
    {1'b1, 2'd2, 4'd10, 8'd77},
    {1'b0, 2'd3, 4'd15, 8'd200},
    {1'b1, 2'd0, 4'd0,  8'd9},
    {1'b0, 2'd0, 4'd0,  8'd12},
    {1'b1, 2'd3, 4'd8,  8'd130}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int b = 0; b < NS; b++)
      for (int a = 0; a < D; a++) begin
        memA[b][a] = CW'(seed < 0 ? 0 : (b*3 + a + seed) % 7);
        memB[b][a] = CW'(seed < 0 ? 0 : (b*5 + a + seed + 2) % 7);
      end
  endtask

  task automatic runScan(input bit midStart);
    int cyc;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (midStart && cyc == 5) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    lastLat = cyc;
    if (cyc >= 200) chk("R2 watchdog", cyc, D + 2);
  endtask

  task automatic expect4(input string req, input int d, input int g, input int fb, input int pk);
    chk({req, " dist"}, int'(distOut), d);
    chk({req, " angle"}, int'(angleOut), g);
    chk({req, " family"}, int'(familyB), fb);
    chk({req, " count"}, int'(peakCount), pk);
  endtask

  initial begin
    fill(-1);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", int'(done), 0);
    chk("R1 noLine", int'(noLine), 0);
    chk("R1 outputs", int'(distOut) + int'(angleOut) + int'(peakCount) + int'(familyB), 0);
    rstN = 1'b1;

    // R3 R6 vector walk
    for (int v = 0; v < 6; v++) begin
      int fam, bank, addr, pk;
      fam = int'(VEC[v][14]); bank = int'(VEC[v][13:12]);
      addr = int'(VEC[v][11:8]); pk = int'(VEC[v][7:0]);
      fill(v);
      if (fam == 1) memB[bank][addr] = CW'(pk); else memA[bank][addr] = CW'(pk);
      runScan(1'b0);
      chk("R2 latency", lastLat, D + 2);
      expect4("R3 R6 vector", addr, (fam == 1 ? 90 : 0) + bank*5, fam, pk);
      chk("R7 noLine clear", int'(noLine), 0);
    end

    // R4 equal counts: lower address beats lower step
    fill(-1); memA[3][2] = 8'd20; memA[0][5] = 8'd20;
    runScan(1'b0); expect4("R4 addr tie", 2, 15, 0, 20);

    // R4 equal counts at one address: lower step wins
    fill(-1); memA[2][7] = 8'd30; memA[1][7] = 8'd30;
    runScan(1'b0); expect4("R4 step tie", 7, 5, 0, 30);

    // R5 family tie: a wins
    fill(2); memA[3][9] = 8'd40; memB[0][1] = 8'd40;
    runScan(1'b0); expect4("R5 family tie", 9, 15, 0, 40);

    // R5 b strictly larger by one, last address, max count
    fill(3); memA[0][4] = 8'd254; memB[3][15] = 8'd255;
    runScan(1'b0); expect4("R5 b wins", 15, 105, 1, 255);

    // R7 all zero
    fill(-1);
    runScan(1'b0);
    chk("R7 noLine", int'(noLine), 1);
    chk("R7 done", int'(done), 1);
    chk("R7 count", int'(peakCount), 0);

    // R9 accepted start clears done and noLine
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R9 done cleared", int'(done), 0);
    chk("R9 noLine cleared", int'(noLine), 0);
    while (!done) @(negedge clk);

    // R8 start mid-scan ignored
    fill(1); memB[1][6] = 8'd60;
    runScan(1'b1);
    chk("R8 latency", lastLat, D + 2);
    expect4("R8 result", 6, 95, 1, 60);

    // R9 hold
    repeat (5) @(negedge clk);
    chk("R9 done held", int'(done), 1);
    expect4("R9 held", 6, 95, 1, 60);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule